// File: doc/BRIEF.md
# Receive Mailbox Bank with Overwrite Protection

This block sits behind a CAN receive engine and files every completed frame into one of a bank of receive mailboxes. Each mailbox holds an identifier word, a control word, two data words and a timestamp. The timestamp is the value of a free-running local time counter at the moment of the store. Every mailbox also carries a pending flag and a lost flag. Per-mailbox inputs select which mailboxes receive and which are protected against being overwritten. Together these let a group of mailboxes act as a queue that fills from the top down. The lowest member can be left unprotected, so an overflow there is flagged rather than silently dropped.

Frames arrive on a valid/ready stream. A frame transfers in any cycle where `in_valid` and `in_ready` are both high. `in_ready` is low during reset and high in every cycle after it, so the block never applies back-pressure once running. A sender may hold `in_valid` high for consecutive cycles; each cycle with both signals high is one frame. Software reaches the flags, the timestamps and the stored words through a simple register port. Reads are combinational. Writes take effect at the clock edge.

Top module: `rx_mailbox_bank`

## Requirements
- R1: An accepted frame goes to the highest-numbered mailbox whose `rx_dir` bit is 1 and which is eligible; a mailbox with `rx_dir` 0 never receives. After a store, that mailbox's bit in the pending register (address 0x00) is 1.
- R2: A mailbox that is pending and has its `ovr_prot` bit at 1 is not eligible; the frame moves on to the next lower eligible mailbox and the protected contents stay unchanged.
- R3: A mailbox that is pending and has its `ovr_prot` bit at 0 is eligible; storing into it replaces the contents and sets its bit in the lost register (address 0x01).
- R4: When no mailbox is eligible, the accepted frame is dropped: pending, lost, flags and all mailbox words stay unchanged.
- R5: Writing 1s to address 0x00 clears the matching pending bits, and 0s have no effect. If a store and a clear hit the same mailbox in one cycle, the store wins and the bit stays 1.
- R6: Writing 1s to address 0x01 clears the matching lost bits; a lost bit set by a store in the same cycle stays 1.
- R7: `lnt_o` is 0 out of reset and rises by 1 every cycle (modulo 2^TS_W). A stored mailbox's timestamp, read at 0x40+m, equals the value `lnt_o` had in the cycle the frame was accepted.
- R8: The identifier word (address 0x80+4m) holds an extended identifier as bit 31 = 1 with the id in bits [28:0]. A standard identifier is held as bit 31 = 0 with the 11-bit id in bits [28:18]. All other bits are 0.
- R9: The control word (0x81+4m) holds DLC in bits [3:0] and the remote flag in bit 4. Data bits [31:0] are read at 0x82+4m and data bits [63:32] at 0x83+4m.
- R10: Flags register (0x02): bit 0 is set when a store turns a pending bit from 0 to 1 for a mailbox whose `int_mask` bit is 1. Bit 1 is set on every store that sets a lost bit. Writing 1s clears the flags, but a set in the same cycle wins. `irq_o` is the OR of the two flags.
- R11: After reset, pending, lost, flags, all mailbox words and `lnt_o` are 0. `in_ready` is 1 from the first cycle after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Frame offered |
| in_ready | output | 1 | Frame can be taken |
| in_id | input | 29 | Identifier (standard ids in bits [10:0]) |
| in_ext | input | 1 | Extended identifier format |
| in_rtr | input | 1 | Remote frame |
| in_dlc | input | 4 | Data length code |
| in_data | input | 64 | Payload |
| rx_dir | input | NUM_MBOX | 1 = mailbox receives |
| ovr_prot | input | NUM_MBOX | 1 = pending mailbox protected |
| int_mask | input | NUM_MBOX | 1 = store raises mailbox flag |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | NUM_MBOX | Write data (1 = clear) |
| reg_rdata | output | 32 | Read data for reg_addr |
| lnt_o | output | TS_W | Local time counter |
| irq_o | output | 1 | Interrupt request |

## Verification
Directed sequences set up a four-deep queue with three protected mailboxes and an unprotected bottom one. Successive frames show the top-down fill order, the skipping of protected entries, the overwrite-and-lost outcome at the bottom, and a full drop once the bottom is also protected. Separate directed cycles put a store and a clear on the same mailbox to settle which one wins, and alternate standard and extended identifiers to check the word layout. Random traffic with fixed seeds then varies the direction, protection and mask vectors while frames and clears interleave. This exposes selection errors when receive mailboxes are scattered across the bank and flag errors when masked mailboxes fill.

// File: rtl/rxmb_pkg.sv
package rxmb_pkg;
  localparam int ID_W   = 29;
  localparam int DLC_W  = 4;
  localparam int DATA_W = 64;
  localparam int WORD_W = 32;

  typedef struct packed {
    logic [ID_W-1:0]   id;
    logic              ext;
    logic              rtr;
    logic [DLC_W-1:0]  dlc;
    logic [DATA_W-1:0] data;
  } rx_frame_t;

  function automatic logic [WORD_W-1:0] id_word(input rx_frame_t f);
    if (f.ext) return {1'b1, 2'b00, f.id};
    return {1'b0, 2'b00, f.id[10:0], 18'd0};
  endfunction

  function automatic logic [WORD_W-1:0] ctrl_word(input rx_frame_t f);
    return {27'd0, f.rtr, f.dlc};
  endfunction
endpackage

// File: rtl/rxmb_timebase.sv
module rxmb_timebase #(
  parameter int TS_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [TS_W-1:0] lnt_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lnt_o <= '0;
    else        lnt_o <= lnt_o + 1'b1;
  end

  p_lnt_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> lnt_o == $past(lnt_o) + 1'b1)
    else $error("time counter did not advance by one");
endmodule

// File: rtl/rxmb_select.sv
module rxmb_select #(
  parameter int N     = 8,
  localparam int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     rx_dir,
  input  logic [N-1:0]     pend,
  input  logic [N-1:0]     prot,
  output logic             hit,
  output logic [IDX_W-1:0] idx,
  output logic             ovw
);
  logic [N-1:0] elig;

  always_comb begin
    elig = rx_dir & ~(pend & prot);
    hit  = 1'b0;
    idx  = '0;
    for (int i = 0; i < N; i++) begin
      if (elig[i]) begin
        hit = 1'b1;
        idx = IDX_W'(i);
      end
    end
    ovw = hit && pend[idx];
  end
endmodule

// File: rtl/rxmb_store.sv
module rxmb_store
  import rxmb_pkg::*;
#(
  parameter int N    = 8,
  parameter int TS_W = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N-1:0]           we,
  input  rx_frame_t              frame,
  input  logic [TS_W-1:0]        lnt_i,
  output logic [N-1:0][WORD_W-1:0] id_o,
  output logic [N-1:0][WORD_W-1:0] ctrl_o,
  output logic [N-1:0][WORD_W-1:0] dlo_o,
  output logic [N-1:0][WORD_W-1:0] dhi_o,
  output logic [N-1:0][TS_W-1:0]   ts_o
);
  logic [WORD_W-1:0] id_new, ctrl_new;

  assign id_new   = id_word(frame);
  assign ctrl_new = ctrl_word(frame);

  for (genvar g = 0; g < N; g++) begin : g_mb
    logic [WORD_W-1:0] id_q, ctrl_q, dlo_q, dhi_q;
    logic [TS_W-1:0]   ts_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        id_q   <= '0;
        ctrl_q <= '0;
        dlo_q  <= '0;
        dhi_q  <= '0;
        ts_q   <= '0;
      end else if (we[g]) begin
        id_q   <= id_new;
        ctrl_q <= ctrl_new;
        dlo_q  <= frame.data[31:0];
        dhi_q  <= frame.data[63:32];
        ts_q   <= lnt_i;
      end
    end

    assign id_o[g]   = id_q;
    assign ctrl_o[g] = ctrl_q;
    assign dlo_o[g]  = dlo_q;
    assign dhi_o[g]  = dhi_q;
    assign ts_o[g]   = ts_q;

    p_ts_capture_r7: assert property (@(posedge clk) disable iff (!rst_n)
      we[g] |=> ts_o[g] == $past(lnt_i))
      else $error("timestamp not captured");

    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !we[g] |=> $stable(id_o[g]) && $stable(ts_o[g]))
      else $error("mailbox changed without store");
  end

  p_one_target_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(we))
    else $error("more than one mailbox written");
endmodule

// File: rtl/rxmb_flags.sv
module rxmb_flags #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] store_vec,
  input  logic         ovw,
  input  logic [N-1:0] clr_pend,
  input  logic [N-1:0] clr_lost,
  input  logic [1:0]   clr_flag,
  input  logic [N-1:0] int_mask,
  output logic [N-1:0] pend_q,
  output logic [N-1:0] lost_q,
  output logic         gm_flag,
  output logic         rml_flag
);
  logic [N-1:0] lost_set, rise;
  logic         gm_set, rml_set;

  assign lost_set = ovw ? store_vec : '0;
  assign rise     = store_vec & ~pend_q;
  assign gm_set   = |(rise & int_mask);
  assign rml_set  = |lost_set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q   <= '0;
      lost_q   <= '0;
      gm_flag  <= 1'b0;
      rml_flag <= 1'b0;
    end else begin
      pend_q   <= (pend_q & ~clr_pend) | store_vec;
      lost_q   <= (lost_q & ~clr_lost) | lost_set;
      gm_flag  <= (gm_flag & ~clr_flag[0]) | gm_set;
      rml_flag <= (rml_flag & ~clr_flag[1]) | rml_set;
    end
  end

  p_lost_on_overwrite_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|(store_vec & pend_q)) |=> (lost_q & $past(store_vec)) == $past(store_vec))
    else $error("overwrite did not set lost bit");

  p_pend_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_pend & ~store_vec)) |=> (pend_q & $past(clr_pend & ~store_vec)) == '0)
    else $error("pending bit not cleared");

  p_rml_raise_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (|(store_vec & pend_q)) |=> rml_flag)
    else $error("lost flag not raised");

  p_gm_raise_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (|(store_vec & ~pend_q & int_mask)) |=> gm_flag)
    else $error("mailbox flag not raised");
endmodule

// File: rtl/rx_mailbox_bank.sv
module rx_mailbox_bank
  import rxmb_pkg::*;
#(
  parameter int NUM_MBOX = 8,
  parameter int TS_W     = 16,
  localparam int IDX_W   = $clog2(NUM_MBOX)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [28:0]         in_id,
  input  logic                in_ext,
  input  logic                in_rtr,
  input  logic [3:0]          in_dlc,
  input  logic [63:0]         in_data,
  input  logic [NUM_MBOX-1:0] rx_dir,
  input  logic [NUM_MBOX-1:0] ovr_prot,
  input  logic [NUM_MBOX-1:0] int_mask,
  input  logic                reg_wr,
  input  logic [7:0]          reg_addr,
  input  logic [NUM_MBOX-1:0] reg_wdata,
  output logic [31:0]         reg_rdata,
  output logic [TS_W-1:0]     lnt_o,
  output logic                irq_o
);
  localparam logic [7:0] A_PEND = 8'h00;
  localparam logic [7:0] A_LOST = 8'h01;
  localparam logic [7:0] A_FLAG = 8'h02;

  rx_frame_t             frame;
  logic                  ready_q, accept, sel_hit, sel_ovw, st_vld;
  logic [IDX_W-1:0]      st_idx;
  logic [NUM_MBOX-1:0]   store_vec, pend_q, lost_q, clr_pend, clr_lost;
  logic [1:0]            clr_flag;
  logic                  gm_flag, rml_flag;
  logic [NUM_MBOX-1:0][WORD_W-1:0] id_w, ctrl_w, dlo_w, dhi_w;
  logic [NUM_MBOX-1:0][TS_W-1:0]   ts_w;
  logic [IDX_W-1:0]      mb_sel, ts_sel;

  assign frame = '{id: in_id, ext: in_ext, rtr: in_rtr, dlc: in_dlc, data: in_data};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= 1'b1;
  end
  assign in_ready = ready_q;
  assign accept   = in_valid && ready_q;

  rxmb_timebase #(.TS_W(TS_W)) u_time (
    .clk(clk), .rst_n(rst_n), .lnt_o(lnt_o)
  );

  rxmb_select #(.N(NUM_MBOX)) u_sel (
    .rx_dir(rx_dir), .pend(pend_q), .prot(ovr_prot),
    .hit(sel_hit), .idx(st_idx), .ovw(sel_ovw)
  );

  assign st_vld    = accept && sel_hit;
  assign store_vec = st_vld ? (NUM_MBOX'(1) << st_idx) : '0;

  assign clr_pend = (reg_wr && reg_addr == A_PEND) ? reg_wdata : '0;
  assign clr_lost = (reg_wr && reg_addr == A_LOST) ? reg_wdata : '0;
  assign clr_flag = (reg_wr && reg_addr == A_FLAG) ? reg_wdata[1:0] : 2'b00;

  rxmb_flags #(.N(NUM_MBOX)) u_flags (
    .clk(clk), .rst_n(rst_n), .store_vec(store_vec), .ovw(sel_ovw && st_vld),
    .clr_pend(clr_pend), .clr_lost(clr_lost), .clr_flag(clr_flag),
    .int_mask(int_mask), .pend_q(pend_q), .lost_q(lost_q),
    .gm_flag(gm_flag), .rml_flag(rml_flag)
  );

  rxmb_store #(.N(NUM_MBOX), .TS_W(TS_W)) u_store (
    .clk(clk), .rst_n(rst_n), .we(store_vec), .frame(frame), .lnt_i(lnt_o),
    .id_o(id_w), .ctrl_o(ctrl_w), .dlo_o(dlo_w), .dhi_o(dhi_w), .ts_o(ts_w)
  );

  assign irq_o  = gm_flag | rml_flag;
  assign mb_sel = reg_addr[IDX_W+1:2];
  assign ts_sel = reg_addr[IDX_W-1:0];

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr[7:6])
      2'b00: begin
        case (reg_addr[5:0])
          6'd0:    reg_rdata = 32'(pend_q);
          6'd1:    reg_rdata = 32'(lost_q);
          6'd2:    reg_rdata = {30'd0, rml_flag, gm_flag};
          default: reg_rdata = '0;
        endcase
      end
      2'b01: if (int'(reg_addr[5:0]) < NUM_MBOX) reg_rdata = 32'(ts_w[ts_sel]);
      2'b10: begin
        if (int'(reg_addr[5:2]) < NUM_MBOX) begin
          case (reg_addr[1:0])
            2'd0: reg_rdata = id_w[mb_sel];
            2'd1: reg_rdata = ctrl_w[mb_sel];
            2'd2: reg_rdata = dlo_w[mb_sel];
            default: reg_rdata = dhi_w[mb_sel];
          endcase
        end
      end
      default: reg_rdata = '0;
    endcase
  end

  p_highest_first_r1: assert property (@(posedge clk) disable iff (!rst_n)
    st_vld |-> ((rx_dir & ~(pend_q & ovr_prot)) >> st_idx) == NUM_MBOX'(1))
    else $error("store target not the highest eligible mailbox");

  p_skip_protected_r2: assert property (@(posedge clk) disable iff (!rst_n)
    st_vld |-> !(pend_q[st_idx] && ovr_prot[st_idx]))
    else $error("protected pending mailbox overwritten");

  p_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !sel_hit && !reg_wr) |=> $stable(pend_q) && $stable(lost_q))
    else $error("dropped frame changed state");

  p_ready_r11: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> in_ready)
    else $error("ready low after reset");
endmodule

// File: tb/rx_mailbox_bank_tb_top.sv
`timescale 1ns/1ps
module rx_mailbox_bank_tb_top;
  localparam int N  = 8;
  localparam int TW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic          in_valid = 0, in_ready, in_ext = 0, in_rtr = 0;
  logic [28:0]   in_id = '0;
  logic [3:0]    in_dlc = '0;
  logic [63:0]   in_data = '0;
  logic [N-1:0]  rx_dir = '0, ovr_prot = '0, int_mask = '0, reg_wdata = '0;
  logic          reg_wr = 0, irq_o;
  logic [7:0]    reg_addr = '0;
  logic [31:0]   reg_rdata;
  logic [TW-1:0] lnt_o;

  rx_mailbox_bank #(.NUM_MBOX(N), .TS_W(TW)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_id(in_id), .in_ext(in_ext), .in_rtr(in_rtr), .in_dlc(in_dlc),
    .in_data(in_data), .rx_dir(rx_dir), .ovr_prot(ovr_prot),
    .int_mask(int_mask), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lnt_o(lnt_o), .irq_o(irq_o)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  logic [N-1:0]  m_pend = '0, m_lost = '0;
  logic [1:0]    m_flag = '0;
  logic [31:0]   m_id [N], m_ctrl [N], m_dlo [N], m_dhi [N];
  logic [TW-1:0] m_ts [N];

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  function automatic int pick();
    for (int i = N-1; i >= 0; i--)
      if (rx_dir[i] && !(m_pend[i] && ovr_prot[i])) return i;
    return -1;
  endfunction

  // one cycle: optional frame plus optional register write; starts and ends at negedge
  task automatic step(input bit v, input logic [28:0] id, input bit ext, input bit rtr,
                      input logic [3:0] dlc, input logic [63:0] dat,
                      input bit w, input logic [7:0] a, input logic [N-1:0] wd);
    int t;
    logic [N-1:0] old_pend;
    in_valid = v; in_id = id; in_ext = ext; in_rtr = rtr; in_dlc = dlc; in_data = dat;
    reg_wr = w; reg_addr = a; reg_wdata = wd;
    t = v ? pick() : -1;
    old_pend = m_pend;
    if (w && a == 8'h00) m_pend = m_pend & ~wd;
    if (w && a == 8'h01) m_lost = m_lost & ~wd;
    if (w && a == 8'h02) m_flag = m_flag & ~wd[1:0];
    if (t >= 0) begin
      if (old_pend[t]) begin m_lost[t] = 1'b1; m_flag[1] = 1'b1; end
      else if (int_mask[t]) m_flag[0] = 1'b1;
      m_pend[t] = 1'b1;
      m_id[t]   = ext ? {1'b1, 2'b00, id} : {1'b0, 2'b00, id[10:0], 18'd0};
      m_ctrl[t] = {27'd0, rtr, dlc};
      m_dlo[t]  = dat[31:0];
      m_dhi[t]  = dat[63:32];
      m_ts[t]   = lnt_o;
    end
    @(posedge clk);
    @(negedge clk);
    in_valid = 0; reg_wr = 0;
  endtask

  task automatic frame(input logic [28:0] id, input bit ext);
    step(1, id, ext, id[0], id[3:0], {id[15:0], ~id[15:0], id[31-3:0], 3'b101}, 0, 8'h00, '0);
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
    @(negedge clk);
  endtask

  task automatic check_all();
    logic [31:0] d;
    rd(8'h00, d); chk("R1", "pending", d, 32'(m_pend));
    rd(8'h01, d); chk("R3", "lost", d, 32'(m_lost));
    rd(8'h02, d); chk("R10", "flags", d, {30'd0, m_flag});
    chk("R10", "irq", 32'(irq_o), 32'(|m_flag));
    for (int m = 0; m < N; m++) begin
      rd(8'h40 + 8'(m), d);     chk("R7", "timestamp", d, 32'(m_ts[m]));
      rd(8'h80 + 8'(4*m), d);   chk("R8", "id word", d, m_id[m]);
      rd(8'h81 + 8'(4*m), d);   chk("R9", "ctrl word", d, m_ctrl[m]);
      rd(8'h82 + 8'(4*m), d);   chk("R9", "data low", d, m_dlo[m]);
      rd(8'h83 + 8'(4*m), d);   chk("R9", "data high", d, m_dhi[m]);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R11 watchdog: actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [TW-1:0] l0;
    for (int m = 0; m < N; m++) begin
      m_id[m] = '0; m_ctrl[m] = '0; m_dlo[m] = '0; m_dhi[m] = '0; m_ts[m] = '0;
    end
    repeat (3) @(negedge clk);
    chk("R11", "ready in reset", 32'(in_ready), 32'd0);
    chk("R11", "time in reset", 32'(lnt_o), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11", "ready after reset", 32'(in_ready), 32'd1);
    l0 = lnt_o;
    @(negedge clk);
    chk("R7", "time step", 32'(lnt_o), 32'(TW'(l0 + 1'b1)));
    check_all();

    // queue of four: 7,6,5 protected, 4 unprotected bottom
    rx_dir = 8'hF0; ovr_prot = 8'hE0; int_mask = 8'hFF;
    frame(29'h123, 0);
    rd(8'h00, d); chk("R1", "first store at top", d, 32'h80);
    frame(29'h1ABCDEF, 1);
    frame(29'h7FF, 0);
    rd(8'h00, d); chk("R2", "protected skipped", d, 32'hE0);
    rd(8'h80 + 8'(4*7), d); chk("R2", "protected kept", d, m_id[7]);
    frame(29'h055, 0);
    frame(29'h1FFFFFFF, 1);
    rd(8'h01, d); chk("R3", "bottom overwrite lost", d, 32'h10);
    rd(8'h02, d); chk("R10", "both flags", d, 32'h3);
    check_all();

    // everything protected and pending: drop
    ovr_prot = 8'hF0;
    frame(29'h0AAAAAA, 1);
    rd(8'h00, d); chk("R4", "drop pending", d, 32'hF0);
    rd(8'h01, d); chk("R4", "drop lost", d, 32'h10);
    rd(8'h80 + 8'(4*4), d); chk("R4", "drop contents", d, m_id[4]);

    // clears
    step(0, '0, 0, 0, '0, '0, 1, 8'h00, 8'h80);
    rd(8'h00, d); chk("R5", "pending cleared", d, 32'h70);
    step(0, '0, 0, 0, '0, '0, 1, 8'h01, 8'hFF);
    rd(8'h01, d); chk("R6", "lost cleared", d, 32'h00);
    step(0, '0, 0, 0, '0, '0, 1, 8'h02, 8'h03);
    chk("R10", "irq cleared", 32'(irq_o), 32'd0);
    // store and clear to mailbox 7 together: store wins
    step(1, 29'h3C3, 0, 1, 4'h8, 64'h0123456789ABCDEF, 1, 8'h00, 8'h80);
    rd(8'h00, d); chk("R5", "store beats clear", d, 32'hF0);
    // overwrite with lost clear in same cycle: set wins
    ovr_prot = 8'h00;
    step(1, 29'h111, 0, 0, 4'h2, 64'h5A5A, 1, 8'h01, 8'hFF);
    rd(8'h01, d); chk("R6", "lost set beats clear", d, 32'h80);
    // non-receive mailboxes never chosen
    rx_dir = 8'h00;
    frame(29'h222, 0);
    check_all();

    // random traffic
    void'($urandom(32'd1234));
    for (int r = 0; r < 600; r++) begin
      if (r % 60 == 0) begin
        rx_dir = N'($urandom); ovr_prot = N'($urandom); int_mask = N'($urandom);
      end
      begin
        bit v, w;
        logic [7:0] a;
        v = ($urandom % 4) != 0;
        w = ($urandom % 3) == 0;
        a = 8'($urandom % 3);
        step(v, 29'($urandom), 1'($urandom), 1'($urandom), 4'($urandom),
             {$urandom, $urandom}, w, a, N'($urandom));
      end
      if (r % 50 == 49) check_all();
    end
    check_all();

    done = 1;
    summary();
    $finish;
  end
endmodule